// File: doc/BRIEF.md
# Sideband AUX Request Engine

This block sits between a register-level requester and a low-level sideband channel. It accepts one request at a time: a native write, a native read, or a single-byte I2C transfer (write, read or address-only) carried over the sideband. From each request it builds a four-byte framed header and hands the header, the total message length and any payload to the channel as a single-cycle issue strobe. It then waits for the channel's response, which carries a low-level status, a reply byte, a byte count and read data.

Each response is classified into one of four outcomes: success, immediate reissue, reissue after a timed back-off, or failure. The timed back-off is a fixed 400 µs, counted in clock cycles. A request gets a bounded number of attempts. The I2C reply field is only considered when the native reply field says ACK. When the request is finished, a one-cycle completion pulse presents a status code, the number of bytes delivered and any read data.

Top module: `aux_req_engine`

## Requirements
- R1: Header byte 0 is address bits [7:0] and byte 1 is address bits [15:8]. Byte 2 holds the command nibble in bits [7:4] and address bits [19:16] in bits [3:0]. The command nibbles are: 8 for a native write (req_cmd 0), 9 for a native read (req_cmd 1), 0 for an I2C write (req_cmd 2), 1 for an I2C read (req_cmd 3) and 0 for I2C address-only (req_cmd 4). For I2C commands, nibble value 4 is OR-ed in when req_stop is low. The header is presented as tx_hdr = {byte3, byte2, byte1, byte0}.
- R2: Byte 3 (the length byte) and tx_len depend on the command:
  - Native write: tx_len is the data count plus 4, and byte 3 is {tx_len[3:0], data count − 1}.
  - Native read: tx_len is 4, and byte 3 is {4, req_len − 1}.
  - I2C write: tx_len is 5 and byte 3 is 0x50.
  - I2C read: tx_len is 4 and byte 3 is 0x40.
  - I2C address-only: tx_len is 4 and byte 3 is 0x30.
- R3: A native write whose length exceeds MAX_BYTES is never issued. It completes in the cycle after acceptance with status 5 (rejected) and count 0.
- R4: A request makes at most MAX_TRIES attempts. If every attempt asks for a retry, the request completes with status 2 (I/O error) for native commands or status 4 (remote failure) for I2C commands. A retry request on the final attempt completes at once, without a back-off.
- R5: Channel status 1 ends the request with status 1 (timeout). Channel status 3 ends it with status 2. Channel status 2 (busy) reissues the request in the cycle right after the response cycle, and that attempt counts.
- R6: With channel status 0, bits [5:4] of the reply byte are the native field: 0 means ACK, 1 NACK, 2 DEFER and 3 invalid.
  - For a native command, ACK completes with status 0.
  - DEFER waits CYC_PER_US*DEFER_US idle cycles after the response cycle and then reissues.
  - NACK or an invalid field fails with status 2, except as given in R7.
- R7: A native read whose native field is NACK or invalid completes with status 3 (protocol error) when rsp_count is 0.
- R8: On success, done_count is:
  - the request length for a native write;
  - min(rsp_count, req_len) for a native read;
  - min(rsp_count, 1) for I2C commands.
  done_data carries rsp_data for reads.
- R9: For I2C commands, bits [7:6] of the reply byte are the I2C field, using the same codes as the native field, and they are considered only after a native ACK.
  - With a native ACK: I2C ACK completes with status 0, I2C DEFER backs off and reissues, and I2C NACK or invalid fails with status 4.
  - A native DEFER backs off and reissues whatever the I2C field holds.
  - A native NACK or invalid field fails with status 4.
- R10: req_ready is low from acceptance until completion. Requests offered in that time are ignored and do not change the frame being issued.
- R11: done is a one-cycle pulse in the cycle after the deciding response (or after acceptance for a rejected write), and follows no other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_cmd | input | 3 | Command code (R1) |
| req_stop | input | 1 | I2C transfer ends with a stop |
| req_addr | input | ADDR_W | Target address |
| req_len | input | clog2(MAX_BYTES+1) | Native data byte count |
| req_wdata | input | 8*MAX_BYTES | Write payload, byte 0 in bits [7:0] |
| tx_valid | output | 1 | Single-cycle issue strobe to the channel |
| tx_hdr | output | 32 | Framed header bytes |
| tx_len | output | clog2(MAX_BYTES+5) | Total message bytes |
| tx_data | output | 8*MAX_BYTES | Payload to the channel |
| rsp_valid | input | 1 | Channel response present |
| rsp_status | input | 2 | Low-level status |
| rsp_reply | input | 8 | Reply byte (native and I2C fields) |
| rsp_count | input | clog2(MAX_BYTES+1) | Bytes returned by the channel |
| rsp_data | input | 8*MAX_BYTES | Returned bytes |
| done | output | 1 | Completion pulse |
| done_status | output | 3 | 0 ok, 1 timeout, 2 I/O, 3 protocol, 4 remote, 5 rejected |
| done_count | output | clog2(MAX_BYTES+1) | Bytes delivered |
| done_data | output | 8*MAX_BYTES | Read data |

## Verification
Some properties are checked on every cycle, inside the engine:
- A rejected write raises done without any issue strobe.
- The attempt counter stays below its bound.
- Acceptance drops req_ready.
- done is always caused by a response or an acceptance.
- A successful native completion never reports more bytes than were asked for.

Other behaviour can only be shown by the bench's scenarios, which compare each frame and completion with an independent model: header and length encodings, the exact reissue gap after busy versus defer, the ordering of the native and I2C reply checks, protocol error versus I/O error, and the status codes on retry exhaustion.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
   typedef enum logic [2:0] {
      CMD_NWR   = 3'd0,
      CMD_NRD   = 3'd1,
      CMD_IWR   = 3'd2,
      CMD_IRD   = 3'd3,
      CMD_IADDR = 3'd4
   } aux_cmd_e;

   typedef enum logic [2:0] {
      ST_OK      = 3'd0,
      ST_TIMEOUT = 3'd1,
      ST_IO      = 3'd2,
      ST_PROTO   = 3'd3,
      ST_REMOTE  = 3'd4,
      ST_REJECT  = 3'd5
   } aux_status_e;

   typedef enum logic [1:0] {
      ACT_DONE,
      ACT_NOW,
      ACT_WAIT,
      ACT_FAIL
   } aux_act_e;

   localparam logic [1:0] LL_TIMEOUT = 2'd1;
   localparam logic [1:0] LL_BUSY    = 2'd2;
   localparam logic [1:0] LL_ERROR   = 2'd3;

   localparam logic [1:0] RP_ACK   = 2'd0;
   localparam logic [1:0] RP_DEFER = 2'd2;

   localparam logic [3:0] NIB_NWR = 4'h8;
   localparam logic [3:0] NIB_NRD = 4'h9;
   localparam logic [3:0] NIB_IWR = 4'h0;
   localparam logic [3:0] NIB_IRD = 4'h1;
   localparam logic [3:0] NIB_MOT = 4'h4;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
   import aux_req_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int MAX_BYTES = 16,
   parameter int LEN_W     = 5,
   parameter int MSG_W     = 5
)(
   input  logic [2:0]        cmd,
   input  logic              stop,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic [31:0]       hdr,
   output logic [MSG_W-1:0]  msg_len,
   output logic              too_long
);
   logic [3:0]       hi_nib;
   logic [3:0]       cmd_nib;
   logic [3:0]       mot;
   logic [3:0]       len_m1;
   logic [7:0]       len_byte;
   logic [MSG_W-1:0] total;

   generate
      if (ADDR_W > 16) begin : g_wide_addr
         assign hi_nib = 4'(addr[ADDR_W-1:16]);
      end else begin : g_narrow_addr
         assign hi_nib = 4'h0;
      end
   endgenerate

   assign mot    = stop ? 4'h0 : NIB_MOT;
   assign len_m1 = 4'(len - 1'b1);

   always_comb begin
      total = MSG_W'(4);
      unique case (cmd)
         CMD_NWR: begin
            cmd_nib  = NIB_NWR;
            total    = MSG_W'(len) + MSG_W'(4);
            len_byte = {total[3:0], len_m1};
         end
         CMD_NRD: begin
            cmd_nib  = NIB_NRD;
            len_byte = {4'h4, len_m1};
         end
         CMD_IWR: begin
            cmd_nib  = NIB_IWR | mot;
            total    = MSG_W'(5);
            len_byte = 8'h50;
         end
         CMD_IRD: begin
            cmd_nib  = NIB_IRD | mot;
            len_byte = 8'h40;
         end
         default: begin
            cmd_nib  = NIB_IWR | mot;
            len_byte = 8'h30;
         end
      endcase
   end

   assign hdr      = {len_byte, cmd_nib, hi_nib, addr[15:8], addr[7:0]};
   assign msg_len  = total;
   assign too_long = (cmd == CMD_NWR) && (int'(len) > MAX_BYTES);
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
   import aux_req_pkg::*;
(
   input  logic        is_i2c,
   input  logic        is_read,
   input  logic        cnt_zero,
   input  logic [1:0]  ll_status,
   input  logic [7:0]  reply,
   output aux_act_e    act,
   output aux_status_e fail_code
);
   logic [1:0] nat_f;
   logic [1:0] i2c_f;

   assign nat_f = reply[5:4];
   assign i2c_f = reply[7:6];

   always_comb begin
      act       = ACT_FAIL;
      fail_code = ST_IO;
      unique case (ll_status)
         LL_TIMEOUT: fail_code = ST_TIMEOUT;
         LL_BUSY:    act = ACT_NOW;
         LL_ERROR:   fail_code = ST_IO;
         default: begin
            if (!is_i2c) begin
               if (nat_f == RP_ACK)        act = ACT_DONE;
               else if (nat_f == RP_DEFER) act = ACT_WAIT;
               else fail_code = (is_read && cnt_zero) ? ST_PROTO : ST_IO;
            end else begin
               fail_code = ST_REMOTE;
               if (nat_f == RP_DEFER) act = ACT_WAIT;
               else if (nat_f == RP_ACK) begin
                  if (i2c_f == RP_ACK)        act = ACT_DONE;
                  else if (i2c_f == RP_DEFER) act = ACT_WAIT;
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/aux_backoff_timer.sv
module aux_backoff_timer #(
   parameter int WAIT_CYC = 80000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   localparam int CW = $clog2(WAIT_CYC + 1);

   logic [CW-1:0] cnt;
   logic          running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start) begin
         cnt     <= CW'(WAIT_CYC - 1);
         running <= 1'b1;
      end else if (running) begin
         if (cnt == '0) running <= 1'b0;
         else           cnt     <= cnt - 1'b1;
      end
   end

   assign expired = running && (cnt == '0);

   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt != '0) |-> !start);
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
   import aux_req_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int MAX_BYTES  = 16,
   parameter int MAX_TRIES  = 4,
   parameter int CYC_PER_US = 200,
   parameter int DEFER_US   = 400
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [2:0]                     req_cmd,
   input  logic                           req_stop,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [$clog2(MAX_BYTES+1)-1:0] req_len,
   input  logic [MAX_BYTES*8-1:0]         req_wdata,
   output logic                           tx_valid,
   output logic [31:0]                    tx_hdr,
   output logic [$clog2(MAX_BYTES+5)-1:0] tx_len,
   output logic [MAX_BYTES*8-1:0]         tx_data,
   input  logic                           rsp_valid,
   input  logic [1:0]                     rsp_status,
   input  logic [7:0]                     rsp_reply,
   input  logic [$clog2(MAX_BYTES+1)-1:0] rsp_count,
   input  logic [MAX_BYTES*8-1:0]         rsp_data,
   output logic                           done,
   output logic [2:0]                     done_status,
   output logic [$clog2(MAX_BYTES+1)-1:0] done_count,
   output logic [MAX_BYTES*8-1:0]         done_data
);
   localparam int LEN_W    = $clog2(MAX_BYTES + 1);
   localparam int MSG_W    = $clog2(MAX_BYTES + 5);
   localparam int DATA_W   = MAX_BYTES * 8;
   localparam int TRY_W    = $clog2(MAX_TRIES + 1);
   localparam int WAIT_CYC = CYC_PER_US * DEFER_US;

   generate
      if (MAX_BYTES < 1 || MAX_BYTES > 16) begin : g_bad_bytes
         $error("MAX_BYTES must be 1..16 to fit the length nibble");
      end
      if (ADDR_W < 16 || ADDR_W > 20) begin : g_bad_addr
         $error("ADDR_W must be 16..20");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("back-off must be at least one cycle");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_BACK} state_e;

   state_e             state;
   logic [31:0]        r_hdr;
   logic [MSG_W-1:0]   r_msg;
   logic [2:0]         r_cmd;
   logic [LEN_W-1:0]   r_len;
   logic [DATA_W-1:0]  r_wdata;
   logic [TRY_W-1:0]   attempt;
   logic [31:0]        b_hdr;
   logic [MSG_W-1:0]   b_msg;
   logic               too_long;
   logic               accept;
   logic               r_i2c;
   logic               last_try;
   aux_act_e           act;
   aux_status_e        fail_code;
   logic               timer_start;
   logic               timer_done;
   logic [LEN_W-1:0]   ok_count;

   aux_hdr_build #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .MSG_W(MSG_W)) u_hdr (
      .cmd(req_cmd), .stop(req_stop), .addr(req_addr), .len(req_len),
      .hdr(b_hdr), .msg_len(b_msg), .too_long(too_long));

   assign r_i2c    = (r_cmd != CMD_NWR) && (r_cmd != CMD_NRD);
   assign last_try = (int'(attempt) == MAX_TRIES - 1);

   aux_reply_decode u_dec (
      .is_i2c(r_i2c), .is_read(r_cmd == CMD_NRD), .cnt_zero(rsp_count == '0),
      .ll_status(rsp_status), .reply(rsp_reply), .act(act), .fail_code(fail_code));

   assign timer_start = (state == S_WAIT) && rsp_valid && (act == ACT_WAIT) && !last_try;

   aux_backoff_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(timer_start), .expired(timer_done));

   always_comb begin
      if (r_cmd == CMD_NWR)      ok_count = r_len;
      else if (r_cmd == CMD_NRD) ok_count = (rsp_count > r_len) ? r_len : rsp_count;
      else                       ok_count = (rsp_count != '0) ? LEN_W'(1) : '0;
   end

   assign req_ready = (state == S_IDLE);
   assign accept    = req_valid && req_ready;
   assign tx_valid  = (state == S_ISSUE);
   assign tx_hdr    = r_hdr;
   assign tx_len    = r_msg;
   assign tx_data   = r_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         r_hdr       <= '0;
         r_msg       <= '0;
         r_cmd       <= '0;
         r_len       <= '0;
         r_wdata     <= '0;
         attempt     <= '0;
         done        <= 1'b0;
         done_status <= ST_OK;
         done_count  <= '0;
         done_data   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: if (accept) begin
               r_hdr   <= b_hdr;
               r_msg   <= b_msg;
               r_cmd   <= req_cmd;
               r_len   <= req_len;
               r_wdata <= req_wdata;
               attempt <= '0;
               if (too_long) begin
                  done        <= 1'b1;
                  done_status <= ST_REJECT;
                  done_count  <= '0;
                  done_data   <= '0;
               end else begin
                  state <= S_ISSUE;
               end
            end
            S_ISSUE: state <= S_WAIT;
            S_WAIT: if (rsp_valid) begin
               unique case (act)
                  ACT_DONE: begin
                     done        <= 1'b1;
                     done_status <= ST_OK;
                     done_count  <= ok_count;
                     done_data   <= rsp_data;
                     state       <= S_IDLE;
                  end
                  ACT_FAIL: begin
                     done        <= 1'b1;
                     done_status <= fail_code;
                     done_count  <= '0;
                     done_data   <= '0;
                     state       <= S_IDLE;
                  end
                  default: begin
                     if (last_try) begin
                        done        <= 1'b1;
                        done_status <= r_i2c ? ST_REMOTE : ST_IO;
                        done_count  <= '0;
                        done_data   <= '0;
                        state       <= S_IDLE;
                     end else begin
                        attempt <= attempt + 1'b1;
                        state   <= (act == ACT_NOW) ? S_ISSUE : S_BACK;
                     end
                  end
               endcase
            end
            S_BACK: if (timer_done) state <= S_ISSUE;
            default: state <= S_IDLE;
         endcase
      end
   end

   p_reject_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && too_long) |=> (done && !tx_valid && done_status == ST_REJECT));

   p_try_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(attempt) < MAX_TRIES);

   p_native_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status == ST_OK && !r_i2c) |-> (done_count <= r_len));

   p_ready_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !too_long) |=> !req_ready);

   p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(rsp_valid) || $past(req_valid)));
endmodule

// File: tb/aux_req_engine_bench.sv
module aux_req_engine_bench;
   localparam int W = 10;   // CYC_PER_US(2) * DEFER_US(5)

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [2:0]   req_cmd = '0;
   logic         req_stop = 1'b0;
   logic [19:0]  req_addr = '0;
   logic [4:0]   req_len = '0;
   logic [127:0] req_wdata = '0;
   logic         tx_valid;
   logic [31:0]  tx_hdr;
   logic [4:0]   tx_len;
   logic [127:0] tx_data;
   logic         rsp_valid = 1'b0;
   logic [1:0]   rsp_status = '0;
   logic [7:0]   rsp_reply = '0;
   logic [4:0]   rsp_count = '0;
   logic [127:0] rsp_data = '0;
   logic         done;
   logic [2:0]   done_status;
   logic [4:0]   done_count;
   logic [127:0] done_data;

   always #2.5 clk = ~clk;

   aux_req_engine #(.CYC_PER_US(2), .DEFER_US(5)) u_aux_req_engine (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_stop(req_stop),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .tx_valid(tx_valid), .tx_hdr(tx_hdr), .tx_len(tx_len), .tx_data(tx_data),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_reply(rsp_reply),
      .rsp_count(rsp_count), .rsp_data(rsp_data),
      .done(done), .done_status(done_status), .done_count(done_count), .done_data(done_data));

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   int s_st[4];
   int s_rep[4];
   int s_cnt[4];
   logic [127:0] wpat = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
   logic [127:0] rpat = 128'hdeadbeef_01234567_89abcdef_5a5aa5a5;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic scr(input int i, input int st, input int rep, input int cnt);
      s_st[i] = st; s_rep[i] = rep; s_cnt[i] = cnt;
   endtask

   task automatic run(input string rq, input int cmd, input bit stop, input int addr,
                      input int len, input bit poke);
      logic [3:0]  nib;
      logic [7:0]  b3;
      logic [31:0] eh;
      int em, est, ecnt, eatt, nat, i2f, k, g, guard;
      int gap_exp[4];
      bit i2c, fin;
      i2c = (cmd >= 2);
      // frame model (R1, R2)
      case (cmd)
         0: begin nib = 4'h8; b3 = {4'((len + 4) & 15), 4'(len - 1)}; em = len + 4; end
         1: begin nib = 4'h9; b3 = {4'h4, 4'(len - 1)}; em = 4; end
         2: begin nib = stop ? 4'h0 : 4'h4; b3 = 8'h50; em = 5; end
         3: begin nib = stop ? 4'h1 : 4'h5; b3 = 8'h40; em = 4; end
         default: begin nib = stop ? 4'h0 : 4'h4; b3 = 8'h30; em = 4; end
      endcase
      eh = {b3, nib, 4'(addr >> 16), 8'(addr >> 8), 8'(addr)};
      // outcome model (R4..R9)
      est = -1; eatt = 0; ecnt = 0;
      for (int a = 0; a < 4; a++) begin
         gap_exp[a] = 0;
         if (est < 0) begin
            eatt = a + 1;
            nat = (s_rep[a] >> 4) & 3;
            i2f = (s_rep[a] >> 6) & 3;
            if (s_st[a] == 1) est = 1;
            else if (s_st[a] == 3) est = 2;
            else if (s_st[a] == 2) gap_exp[a] = 0;
            else if (!i2c) begin
               if (nat == 0) begin
                  est = 0;
                  ecnt = (cmd == 0) ? len : ((s_cnt[a] > len) ? len : s_cnt[a]);
               end else if (nat == 2) gap_exp[a] = W;
               else est = (cmd == 1 && s_cnt[a] == 0) ? 3 : 2;
            end else begin
               if (nat == 2) gap_exp[a] = W;
               else if (nat != 0) est = 4;
               else if (i2f == 0) begin est = 0; ecnt = (s_cnt[a] > 0) ? 1 : 0; end
               else if (i2f == 2) gap_exp[a] = W;
               else est = 4;
            end
         end
      end
      if (est < 0) est = i2c ? 4 : 2;
      if (cmd == 0 && len > 16) begin est = 5; eatt = 0; ecnt = 0; end

      @(negedge clk);
      chk(req_ready == 1'b1, rq, "R10 idle ready", 128'(req_ready), 1);
      req_valid = 1'b1; req_cmd = 3'(cmd); req_stop = stop; req_addr = 20'(addr);
      req_len = 5'(len); req_wdata = wpat;
      @(negedge clk);
      req_valid = poke;
      if (poke) begin req_cmd = 3'd1; req_addr = 20'h0_0bad; req_len = 5'd2; end
      k = 0; g = 0; guard = 0; fin = 0;
      while (!fin && guard < 3000) begin
         guard++;
         if (done) begin
            chk(done_status == 3'(est), rq, "status", 128'(done_status), 128'(est));
            chk(done_count == 5'(ecnt), rq, "R8 count", 128'(done_count), 128'(ecnt));
            chk(k == eatt, rq, "R4 attempts", 128'(k), 128'(eatt));
            chk(g == 0, rq, "R11 done timing", 128'(g), 0);
            if (est == 0 && cmd == 1)
               chk(done_data == rpat, rq, "R8 read data", done_data, rpat);
            if (est == 0 && cmd == 3)
               chk(done_data[7:0] == rpat[7:0], rq, "R9 i2c byte", 128'(done_data[7:0]), 128'(rpat[7:0]));
            fin = 1;
            @(negedge clk);
            chk(done == 1'b0, rq, "R11 pulse width", 128'(done), 0);
         end else if (tx_valid) begin
            chk(tx_hdr == eh, rq, "R1 header", 128'(tx_hdr), 128'(eh));
            chk(tx_len == 5'(em), rq, "R2 msg length", 128'(tx_len), 128'(em));
            if (cmd == 0) chk(tx_data == wpat, rq, "payload", tx_data, wpat);
            if (cmd == 2) chk(tx_data[7:0] == wpat[7:0], rq, "i2c payload", 128'(tx_data[7:0]), 128'(wpat[7:0]));
            if (k > 0) chk(g == gap_exp[k-1], rq, "R5/R6 reissue gap", 128'(g), 128'(gap_exp[k-1]));
            if (poke) chk(req_ready == 1'b0, rq, "R10 busy ready", 128'(req_ready), 0);
            @(negedge clk);
            req_valid = 1'b0;
            rsp_valid = 1'b1;
            rsp_status = 2'(s_st[(k < 4) ? k : 3]);
            rsp_reply  = 8'(s_rep[(k < 4) ? k : 3]);
            rsp_count  = 5'(s_cnt[(k < 4) ? k : 3]);
            rsp_data   = rpat;
            @(negedge clk);
            rsp_valid = 1'b0;
            k++; g = 0;
            if (poke && !done) req_valid = 1'b1;
         end else begin
            g++;
            @(negedge clk);
         end
      end
      if (!fin) chk(1'b0, rq, "no completion", 0, 1);
      req_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) scr(i, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "reset", "R10 ready", 128'(req_ready), 1);
      chk(done == 1'b0, "reset", "R11 done", 128'(done), 0);
      chk(tx_valid == 1'b0, "reset", "R1 tx idle", 128'(tx_valid), 0);

      scr(0, 0, 8'h00, 0);                         run("R1 native write", 0, 0, 20'h12345, 4, 0);
      scr(0, 0, 8'h00, 12);                        run("R8 read clamp", 1, 0, 20'h00200, 8, 0);
      run("R3 too long", 0, 0, 20'h00010, 17, 0);
      scr(0, 0, 8'h00, 0);                         run("R2 16-byte write", 0, 0, 20'hf0102, 16, 0);
      scr(0, 2, 0, 0); scr(1, 2, 0, 0); scr(2, 0, 8'h00, 3);
                                                   run("R5 busy reissue R10", 1, 0, 20'h00300, 6, 1);
      scr(0, 0, 8'h20, 0); scr(1, 0, 8'h00, 0);    run("R6 native defer R10", 0, 0, 20'h00404, 2, 1);
      scr(0, 1, 0, 0);                             run("R5 timeout", 1, 0, 20'h00500, 1, 0);
      scr(0, 3, 0, 0);                             run("R5 channel error", 0, 0, 20'h00500, 1, 0);
      scr(0, 0, 8'h10, 0);                         run("R7 read nack empty", 1, 0, 20'h00600, 4, 0);
      scr(0, 0, 8'h10, 2);                         run("R7 read nack data", 1, 0, 20'h00600, 4, 0);
      scr(0, 0, 8'h10, 0);                         run("R6 write nack", 0, 0, 20'h00600, 4, 0);
      for (int i = 0; i < 4; i++) scr(i, 2, 0, 0);
                                                   run("R4 native exhaust", 0, 0, 20'h00700, 4, 0);
      scr(0, 0, 8'h00, 1);                         run("R9 i2c read mot", 3, 0, 20'h00050, 0, 0);
      scr(0, 0, 8'h80, 0); scr(1, 0, 8'h00, 1);    run("R9 i2c defer write", 2, 1, 20'h00050, 0, 0);
      scr(0, 0, 8'h10, 0);                         run("R9 addr-only nack", 4, 0, 20'h00050, 0, 0);
      for (int i = 0; i < 4; i++) scr(i, 0, 8'h60, 0);
                                                   run("R9 R4 i2c native defer", 3, 1, 20'h00051, 0, 0);
      scr(0, 0, 8'h40, 1);                         run("R9 i2c nack", 3, 1, 20'h00052, 0, 0);
      scr(0, 0, 8'h00, 4);                         run("R8 i2c clamp", 3, 1, 20'h00053, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule